// File: doc/BRIEF.md
# Nibble Logic Execute Unit

This unit carries out the exclusive-OR and bit-test instructions of a 4-bit accumulator core. It receives a 13-bit instruction word with a start strobe. It decodes the operand form and reads or writes a 4-bit data memory through a simple port. It also updates the architectural registers it owns: the accumulators A and B, the 16-bit index registers X and Y, and the 4-bit flag register F. Bit 0 of F is the zero flag. Bit 1 of F is the carry flag.

Exclusive-OR places its result in the destination. Bit-test forms the bitwise AND of the two operands only to set the zero flag, and it stores nothing. Forms with a register destination finish in one clock. Forms with a memory destination take two clocks: a read, then a write. An index named with a trailing "+" is incremented after the access.

The memory read path is combinational: `mem_rdata` must reflect `mem_addr` within the same cycle. Writes happen at the clock edge while `mem_wr` is high.

Top module: `nibble_logic_unit`

## Requirements
- R1: After reset, A, B, X, Y and F read zero, and `busy` and `done` are low.
- R2: Register and immediate forms with exclusive-OR write dst^src into A or B. Bits [12:7] are 110111 and bit 6 is 1. `[5:4]`=00 means A,imm and 01 means B,imm, with the immediate in [3:0]. `[5:3]`=110 is register-to-register, with [2] the destination (0=A, 1=B), [1] the source (0=A, 1=B) and [0] ignored. F[0] is set exactly when the 4-bit result is zero, and F[3:1] are kept.
- R3: Bit-test uses the same layout with [12:7]=110101. It sets F[0] from (dst & src)==0 and leaves A, B and memory unchanged.
- R4: `[5:3]`=100 selects a register destination with a memory source, completed in one cycle. [2] selects A or B, [1] selects Y (1) or X (0), and [0] selects post-increment.
- R5: `[5:3]`=101 selects a memory destination with a register source: [2] selects B (1) or A (0), [1] selects Y, and [0] selects post-increment. Bit 6 = 0 selects a memory destination with an immediate source: [5] selects Y, [4] selects post-increment, and [3:0] holds the immediate. These take two cycles, with `busy` high in the second. With exclusive-OR, the write goes to the address that was read.
- R6: Bit-test with a memory destination still takes two cycles but issues no write.
- R7: Post-increment adds one to the index after its access, and 0xFFFF wraps to 0x0000.
- R8: Opcode 100001010 in [12:4] replaces F with F^imm4. This is the only way to change F[1].
- R9: A start seen while `busy` is high is ignored.
- R10: An undefined opcode changes no register and makes no memory access, but still yields `done`.
- R11: `done` is high for the one cycle that follows the clock edge that completes an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction present on `instr` |
| instr | input | 13 | Instruction word |
| busy | output | 1 | Second (write) cycle in progress |
| done | output | 1 | Instruction completed on the previous edge |
| mem_addr | output | ADDR_W | Data memory address (X or Y) |
| mem_rd | output | 1 | Memory read this cycle |
| mem_wr | output | 1 | Memory write at this edge |
| mem_wdata | output | 4 | Write data |
| mem_rdata | input | 4 | Read data, valid in the same cycle |
| reg_a | output | 4 | Accumulator A |
| reg_b | output | 4 | Accumulator B |
| reg_x | output | ADDR_W | Index X |
| reg_y | output | ADDR_W | Index Y |
| reg_f | output | 4 | Flags, bit 0 zero, bit 1 carry |

## Verification
The bench targets several corner cases, each of which a faulty design would get wrong in a visible way:
- Bit-test with a memory destination. A unit that writes the AND back would corrupt memory.
- The don't-care bit 0 of register forms. A decoder that misreads it would swap operands.
- Post-increment. It must land after the access, and the index must wrap at 0xFFFF instead of saturating or incrementing before the read.
- An instruction offered during the write cycle. A careless handshake would execute it.
- A zero-result exclusive-OR following a flag load. It must keep the carry bit that the load placed in F.

// File: rtl/nlu_pkg.sv
package nlu_pkg;
  localparam int NIB_W   = 4;
  localparam int INSTR_W = 13;

  typedef enum logic [1:0] {DST_A, DST_B, DST_MEM, DST_F} dst_e;
  typedef enum logic [1:0] {SRC_A, SRC_B, SRC_IMM, SRC_MEM} src_e;

  typedef struct packed {
    logic             valid;
    logic             is_bit;
    dst_e             dst;
    src_e             src;
    logic             use_y;
    logic             post_inc;
    logic [NIB_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/nlu_rst_sync.sv
module nlu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/nlu_decode.sv
module nlu_decode
  import nlu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  localparam logic [8:0] FLAG_OP  = 9'b100001010;
  localparam logic [5:0] XOR_PFX  = 6'b110111;
  localparam logic [5:0] BIT_PFX  = 6'b110101;

  logic fam_hit;
  assign fam_hit = (instr[12:7] == XOR_PFX) || (instr[12:7] == BIT_PFX);

  always_comb begin
    dec          = '0;
    dec.dst      = DST_A;
    dec.src      = SRC_A;
    dec.imm      = instr[3:0];
    dec.is_bit   = (instr[12:7] == BIT_PFX);
    if (instr[12:4] == FLAG_OP) begin
      dec.valid  = 1'b1;
      dec.is_bit = 1'b0;
      dec.dst    = DST_F;
      dec.src    = SRC_IMM;
    end else if (fam_hit) begin
      if (!instr[6]) begin
        dec.valid    = 1'b1;
        dec.dst      = DST_MEM;
        dec.src      = SRC_IMM;
        dec.use_y    = instr[5];
        dec.post_inc = instr[4];
      end else if (!instr[5]) begin
        dec.valid = 1'b1;
        dec.dst   = instr[4] ? DST_B : DST_A;
        dec.src   = SRC_IMM;
      end else begin
        unique case (instr[4:3])
          2'b00: begin
            dec.valid    = 1'b1;
            dec.dst      = instr[2] ? DST_B : DST_A;
            dec.src      = SRC_MEM;
            dec.use_y    = instr[1];
            dec.post_inc = instr[0];
          end
          2'b01: begin
            dec.valid    = 1'b1;
            dec.dst      = DST_MEM;
            dec.src      = instr[2] ? SRC_B : SRC_A;
            dec.use_y    = instr[1];
            dec.post_inc = instr[0];
          end
          2'b10: begin
            dec.valid = 1'b1;
            dec.dst   = instr[2] ? DST_B : DST_A;
            dec.src   = instr[1] ? SRC_B : SRC_A;
          end
          default: dec.valid = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/nlu_alu.sv
module nlu_alu #(
  parameter int W = 4
) (
  input  logic         is_bit,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res,
  output logic         zero
);
  always_comb begin
    res  = is_bit ? (lhs & rhs) : (lhs ^ rhs);
    zero = (res == '0);
  end
endmodule

// File: rtl/nibble_logic_unit.sv
module nibble_logic_unit
  import nlu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  output logic               busy,
  output logic               done,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [NIB_W-1:0]   mem_wdata,
  input  logic [NIB_W-1:0]   mem_rdata,
  output logic [NIB_W-1:0]   reg_a,
  output logic [NIB_W-1:0]   reg_b,
  output logic [ADDR_W-1:0]  reg_x,
  output logic [ADDR_W-1:0]  reg_y,
  output logic [NIB_W-1:0]   reg_f
);
  localparam logic [ADDR_W-1:0] IDX_ONE = ADDR_W'(1);

  typedef enum logic {S_IDLE, S_WRITE} state_e;

  logic rst_n_s;
  nlu_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  state_e            state_q, state_d;
  dec_t              cur_dec, held_q, act;
  logic [NIB_W-1:0]  a_q, b_q, f_q, rdata_q;
  logic [NIB_W-1:0]  a_d, b_d, f_d;
  logic [ADDR_W-1:0] x_q, y_q, x_d, y_d;
  logic              done_q;
  logic              accept, finish, commit;
  logic              a_en, b_en, f_en, x_en, y_en;
  logic [NIB_W-1:0]  lhs, rhs, res;
  logic              zero;

  nlu_decode u_dec (.instr(instr), .dec(cur_dec));

  // Next-state logic
  always_comb begin
    accept = start && (state_q == S_IDLE);
    act    = (state_q == S_WRITE) ? held_q : cur_dec;
    finish = (state_q == S_WRITE) ||
             (accept && !(cur_dec.valid && cur_dec.dst == DST_MEM));
    commit = finish && act.valid;

    state_d = state_q;
    if (state_q == S_WRITE)                                state_d = S_IDLE;
    else if (accept && cur_dec.valid && cur_dec.dst == DST_MEM) state_d = S_WRITE;

    mem_addr = act.use_y ? y_q : x_q;
    mem_rd   = accept && cur_dec.valid &&
               (cur_dec.src == SRC_MEM || cur_dec.dst == DST_MEM);

    unique case (act.dst)
      DST_A:   lhs = a_q;
      DST_B:   lhs = b_q;
      DST_F:   lhs = f_q;
      default: lhs = rdata_q;
    endcase
    unique case (act.src)
      SRC_A:   rhs = a_q;
      SRC_B:   rhs = b_q;
      SRC_IMM: rhs = act.imm;
      default: rhs = mem_rdata;
    endcase
  end

  nlu_alu #(.W(NIB_W)) u_alu (
    .is_bit(act.is_bit), .lhs(lhs), .rhs(rhs), .res(res), .zero(zero)
  );

  always_comb begin
    a_en = commit && !act.is_bit && (act.dst == DST_A);
    b_en = commit && !act.is_bit && (act.dst == DST_B);
    f_en = commit;
    a_d  = res;
    b_d  = res;
    f_d  = (act.dst == DST_F) ? res : {f_q[NIB_W-1:1], zero};
    x_en = commit && act.post_inc && !act.use_y;
    y_en = commit && act.post_inc &&  act.use_y;
    x_d  = x_q + IDX_ONE;
    y_d  = y_q + IDX_ONE;
    mem_wr    = (state_q == S_WRITE) && held_q.valid && !held_q.is_bit;
    mem_wdata = res;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_IDLE;
      held_q  <= '0;
      rdata_q <= '0;
      a_q     <= '0;
      b_q     <= '0;
      f_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (accept) held_q  <= cur_dec;
      if (accept) rdata_q <= mem_rdata;
      if (a_en)   a_q     <= a_d;
      if (b_en)   b_q     <= b_d;
      if (f_en)   f_q     <= f_d;
      if (x_en)   x_q     <= x_d;
      if (y_en)   y_q     <= y_d;
    end
  end

  assign busy  = (state_q == S_WRITE);
  assign done  = done_q;
  assign reg_a = a_q;
  assign reg_b = b_q;
  assign reg_f = f_q;
  assign reg_x = x_q;
  assign reg_y = y_q;

  // Checks beside the control they guard
  assert_write_in_second_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_wr |-> (busy && !mem_rd));
  assert_busy_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |=> (!busy && done));
  assert_regs_hold_in_write_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |=> ($stable(reg_a) && $stable(reg_b)));
  assert_x_steps_by_one_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_x != $past(reg_x)) |-> (reg_x == $past(reg_x) + IDX_ONE));
  assert_y_steps_by_one_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_y != $past(reg_y)) |-> (reg_y == $past(reg_y) + IDX_ONE));
  assert_carry_only_by_flag_op_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(accept && cur_dec.valid && cur_dec.dst == DST_F) |=> $stable(reg_f[1]));
  assert_undefined_no_access_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && !cur_dec.valid) |-> (!mem_rd && !mem_wr));
endmodule

// File: tb/nibble_logic_unit_test.sv
`timescale 1ns/1ps
module nibble_logic_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] instr = '0;
  logic        busy, done, mem_rd, mem_wr;
  logic [15:0] mem_addr, reg_x, reg_y;
  logic [3:0]  mem_wdata, mem_rdata, reg_a, reg_b, reg_f;

  logic [3:0]  mem [256];
  int          wr_cnt = 0;
  logic [15:0] wr_addr;
  logic [3:0]  wr_data;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  nibble_logic_unit #(.ADDR_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .reg_a(reg_a), .reg_b(reg_b), .reg_x(reg_x), .reg_y(reg_y), .reg_f(reg_f)
  );

  always_comb mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) begin
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt  <= wr_cnt + 1;
      wr_addr <= mem_addr;
      wr_data <= mem_wdata;
    end
  end

  // ins, A, B, X[3:0], Y[3:0], F, cycles, write?, write addr, write data
  localparam int NV = 18;
  localparam logic [43:0] VECS [NV] = '{
    {13'b110111_1_00_1100, 4'hC, 4'h0, 4'h0, 4'h0, 4'h0, 2'd1, 1'b0, 4'h0, 4'h0}, // R2 A,imm
    {13'b110111_1_01_0011, 4'hC, 4'h3, 4'h0, 4'h0, 4'h0, 2'd1, 1'b0, 4'h0, 4'h0}, // R2 B,imm
    {13'b110111_1_110011,  4'hF, 4'h3, 4'h0, 4'h0, 4'h0, 2'd1, 1'b0, 4'h0, 4'h0}, // R2 A,B bit0=1
    {13'b110111_1_110110,  4'hF, 4'h0, 4'h0, 4'h0, 4'h1, 2'd1, 1'b0, 4'h0, 4'h0}, // R2 B,B zero
    {13'b100001010_0001,   4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 2'd1, 1'b0, 4'h0, 4'h0}, // R8 F^1
    {13'b110111_1_100001,  4'hA, 4'h0, 4'h1, 4'h0, 4'h0, 2'd1, 1'b0, 4'h0, 4'h0}, // R4 A,[X]+
    {13'b110101_1_100010,  4'hA, 4'h0, 4'h1, 4'h0, 4'h1, 2'd1, 1'b0, 4'h0, 4'h0}, // R3 bit A,[Y]
    {13'b110111_1_101101,  4'hA, 4'h0, 4'h2, 4'h0, 4'h0, 2'd2, 1'b1, 4'h1, 4'h6}, // R5 [X]+,B
    {13'b110111_1_101010,  4'hA, 4'h0, 4'h2, 4'h0, 4'h0, 2'd2, 1'b1, 4'h0, 4'hF}, // R5 [Y],A
    {13'b110101_0_00_1000, 4'hA, 4'h0, 4'h2, 4'h0, 4'h1, 2'd2, 1'b0, 4'h0, 4'h0}, // R6 bit [X],8
    {13'b110111_0_11_1111, 4'hA, 4'h0, 4'h2, 4'h1, 4'h1, 2'd2, 1'b1, 4'h0, 4'h0}, // R7 [Y]+,F
    {13'b110101_1_00_0010, 4'hA, 4'h0, 4'h2, 4'h1, 4'h0, 2'd1, 1'b0, 4'h0, 4'h0}, // R3 bit A,2
    {13'b100001010_1110,   4'hA, 4'h0, 4'h2, 4'h1, 4'hE, 2'd1, 1'b0, 4'h0, 4'h0}, // R8 F^E
    {13'b110111_1_110000,  4'h0, 4'h0, 4'h2, 4'h1, 4'hF, 2'd1, 1'b0, 4'h0, 4'h0}, // R2 A,A keeps C
    {13'b110101_1_101111,  4'h0, 4'h0, 4'h2, 4'h2, 4'hF, 2'd2, 1'b0, 4'h0, 4'h0}, // R6 bit [Y]+,B
    {13'b110111_1_111000,  4'h0, 4'h0, 4'h2, 4'h2, 4'hF, 2'd1, 1'b0, 4'h0, 4'h0}, // R10 undefined
    {13'b110111_1_100111,  4'h0, 4'h7, 4'h2, 4'h3, 4'hE, 2'd1, 1'b0, 4'h0, 4'h0}, // R4 B,[Y]+
    {13'b110111_1_110100,  4'h0, 4'h7, 4'h2, 4'h3, 4'hE, 2'd1, 1'b0, 4'h0, 4'h0}  // R2 B,A
  };

  function automatic string vec_tag(input int i);
    case (i)
      4, 12:     return "R8";
      5, 16:     return "R4";
      6, 11:     return "R3";
      7, 8:      return "R5";
      9, 14:     return "R6";
      10:        return "R7";
      15:        return "R10";
      default:   return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [12:0] ins, input bit junk, output int cyc,
                     output logic done_mid, output logic done_end);
    @(negedge clk);
    start = 1'b1;
    instr = ins;
    @(negedge clk);
    cyc      = 1;
    done_mid = 1'b0;
    if (busy) begin
      cyc      = 2;
      done_mid = done;
      if (junk) instr = 13'b110111_1_00_0101;
      else      start = 1'b0;
      @(negedge clk);
    end
    start    = 1'b0;
    done_end = done;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog expired: got hung expected finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int          cyc;
    logic        dmid, dend;
    logic [43:0] v;
    int          w0;
    for (int i = 0; i < 256; i++) mem[i] = 4'(i + 5);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "A", 16'(reg_a), 16'h0);
    chk("R1", "B", 16'(reg_b), 16'h0);
    chk("R1", "X", reg_x, 16'h0);
    chk("R1", "Y", reg_y, 16'h0);
    chk("R1", "F", 16'(reg_f), 16'h0);
    chk("R1", "busy/done", {14'h0, busy, done}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      v  = VECS[i];
      w0 = wr_cnt;
      run(v[43:31], 1'b0, cyc, dmid, dend);
      chk(vec_tag(i), $sformatf("vec%0d A", i), 16'(reg_a), 16'(v[30:27]));
      chk(vec_tag(i), $sformatf("vec%0d B", i), 16'(reg_b), 16'(v[26:23]));
      chk(vec_tag(i), $sformatf("vec%0d X", i), reg_x, 16'(v[22:19]));
      chk(vec_tag(i), $sformatf("vec%0d Y", i), reg_y, 16'(v[18:15]));
      chk(vec_tag(i), $sformatf("vec%0d F", i), 16'(reg_f), 16'(v[14:11]));
      chk(vec_tag(i), $sformatf("vec%0d cycles", i), 16'(cyc), 16'(v[10:9]));
      chk(vec_tag(i), $sformatf("vec%0d writes", i), 16'(wr_cnt - w0), 16'(v[8]));
      if (v[8]) begin
        chk(vec_tag(i), $sformatf("vec%0d wr addr", i), wr_addr, 16'(v[7:4]));
        chk(vec_tag(i), $sformatf("vec%0d wr data", i), 16'(wr_data), 16'(v[3:0]));
      end
      chk("R11", $sformatf("vec%0d done pulse", i), {14'h0, dmid, dend}, 16'h1);
    end
    // R6 bit-test left its target untouched; R5 writes landed
    chk("R6", "mem[2] after bit-test", 16'(mem[2]), 16'h7);
    chk("R5", "mem[1]", 16'(mem[1]), 16'h6);
    chk("R7", "mem[0]", 16'(mem[0]), 16'h0);

    // R7 wrap of X: bit-test A,[X]+ steps X from 2 to 0xFFFF, then to 0
    for (int k = 0; k < 65533; k++) run(13'b110101_1_100001, 1'b0, cyc, dmid, dend);
    chk("R7", "X at top", reg_x, 16'hFFFF);
    run(13'b110101_1_100001, 1'b0, cyc, dmid, dend);
    chk("R7", "X wrapped", reg_x, 16'h0000);
    chk("R3", "A unchanged by bit-test", 16'(reg_a), 16'h0);

    // R9: a start offered during the write cycle is dropped
    run(13'b110111_1_00_1001, 1'b0, cyc, dmid, dend);
    chk("R2", "A after A^9", 16'(reg_a), 16'h9);
    chk("R2", "F after A^9", 16'(reg_f), 16'hE);
    w0 = wr_cnt;
    run(13'b110111_1_101000, 1'b1, cyc, dmid, dend);
    @(negedge clk);
    chk("R9", "A after ignored start", 16'(reg_a), 16'h9);
    chk("R9", "mem[0] written", 16'(mem[0]), 16'h9);
    chk("R9", "single write", 16'(wr_cnt - w0), 16'h1);
    chk("R9", "busy after", {15'h0, busy}, 16'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule